// File: doc/BRIEF.md
# Accelerator Input Handshake Controller

This block feeds preprocessed image frames from a pixel stream into external memory on behalf of a neural-network accelerator. It waits for a software start bit. Once the bit is set, it uses a single-beat AXI4 register master to ask the accelerator three things: whether an input buffer is free, where that buffer is, and how many bytes a frame occupies. It then opens a write burst on a simple memory write-request port and forwards exactly that many 32-bit pixel beats from the stream. Incoming pixels are held off with `px_ready` whenever no frame write is open.

When the memory reports that the frame has landed, the controller tells the accelerator a new input is ready. It does this by writing 1 and then 0 to the accelerator's "next input" register. It then starts the next frame, and it re-reads the buffer address every time, because the accelerator rotates through a small ring of buffers (three by default). Clearing the start bit stops the loop only at a frame boundary. Any AXI response other than OKAY latches an error and parks the controller until reset.

Top module: `accel_feed_ctrl`

## Requirements
- R1: After reset, and while `start_en` has not yet been set, the block issues no AXI read or write, holds `px_ready` low and holds `err_flag` low.
- R2: Each frame begins with single-beat AXI reads in a fixed order. The first read is the valid register at offset 0x00. Only after bit 0 of that register reads 1 does the block read the buffer address at 0x04, and then the frame size in bytes at 0x08.
- R3: When the valid register reads 0, the valid read is repeated no sooner than max(`poll_gap`, 16) cycles later. There are no reads in between.
- R4: Once the size is known, `mw_start` pulses for one cycle. It carries `mw_addr` equal to the address register value and `mw_len` equal to the size divided by 4 (bytes per beat).
- R5: Exactly `mw_len` beats are then forwarded, each beat being a cycle with `mw_valid` and `mw_ready` high. They go out in stream order, with `mw_data` equal to the accepted pixel. `px_ready` is high only while a frame write has beats outstanding.
- R6: No write to the next register (offset 0x0C) with data 1 occurs before the `mw_done` pulse of the current frame.
- R7: After `mw_done`, the block writes 1 and then 0 to offset 0x0C. Each write waits for its write response before anything further is issued.
- R8: While `start_en` stays set, frames repeat without another start. The address and size registers are read again for every frame, so buffers in a rotating ring are each targeted in turn.
- R9: Clearing `start_en` during a frame does not cut it short. That frame completes, including both next-register writes, and only then does the block go idle and issue no further reads.
- R10: A read or write response other than OKAY (code 0) sets `err_flag`. The flag stays set, and from then on the block issues no AXI request and holds `px_ready` low, regardless of `start_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_en | input | 1 | Software run bit |
| poll_gap | input | GAP_W | Re-poll delay in cycles; values below 16 act as 16 |
| m_ar_valid | output | 1 | Register read address valid |
| m_ar_ready | input | 1 | Register read address ready |
| m_ar_addr | output | AW | Register read address |
| m_r_valid | input | 1 | Read data valid |
| m_r_ready | output | 1 | Read data ready |
| m_r_data | input | DW | Read data |
| m_r_resp | input | 2 | Read response, 0 = OKAY |
| m_aw_valid | output | 1 | Register write address valid |
| m_aw_ready | input | 1 | Register write address ready |
| m_aw_addr | output | AW | Register write address |
| m_w_valid | output | 1 | Write data valid |
| m_w_ready | input | 1 | Write data ready |
| m_w_data | output | DW | Write data |
| m_b_valid | input | 1 | Write response valid |
| m_b_ready | output | 1 | Write response ready |
| m_b_resp | input | 2 | Write response, 0 = OKAY |
| px_valid | input | 1 | Pixel beat valid |
| px_ready | output | 1 | Pixel beat accepted |
| px_data | input | DW | Packed pixel beat |
| mw_start | output | 1 | One-cycle frame-write open |
| mw_addr | output | AW | Frame base address |
| mw_len | output | DW | Beats in frame |
| mw_valid | output | 1 | Memory write beat valid |
| mw_ready | input | 1 | Memory accepts beat |
| mw_data | output | DW | Memory write beat |
| mw_done | input | 1 | Memory frame-write done pulse |
| err_flag | output | 1 | Sticky bus error |

## Verification
A read response reaches the control FSM one cycle after its R handshake. The next request follows two cycles later. `mw_start` appears one cycle after the size response is consumed, and beats may flow in that same cycle. For these reasons the bench does not predict exact cycle numbers for handshakes. It samples every handshake at the falling edge, between the edges where it takes effect, and checks ordering and counts: which register each read targets, how many beats each frame carries, and whether `mw_done` came before the 1-write. Only the re-poll spacing is timed, and it must lie between the effective gap and that gap plus ten cycles. The quiet periods after a stop or an error are checked by counting handshakes over a window of 100 cycles or more.

// File: rtl/accel_feed_pkg.sv
package accel_feed_pkg;
  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_VALID, S_WAIT_GAP, S_RD_ADDR, S_RD_SIZE,
    S_STREAM, S_WAIT_DONE, S_NEXT_SET, S_NEXT_CLR, S_HALT
  } afc_state_t;

  typedef enum logic [2:0] {M_IDLE, M_AR, M_R, M_W, M_B} afc_mst_t;

  function automatic int unsigned floor_gap(int unsigned g, int unsigned lo);
    return (g < lo) ? lo : g;
  endfunction

  function automatic int unsigned beat_shift(int unsigned data_w);
    return $clog2(data_w / 8);
  endfunction
endpackage

// File: rtl/afc_reg_master.sv
module afc_reg_master
  import accel_feed_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          is_wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          done,
  output logic          bad,
  output logic [DW-1:0] rdata,
  output logic          ar_valid,
  input  logic          ar_ready,
  output logic [AW-1:0] ar_addr,
  input  logic          r_valid,
  output logic          r_ready,
  input  logic [DW-1:0] r_data,
  input  logic [1:0]    r_resp,
  output logic          aw_valid,
  input  logic          aw_ready,
  output logic [AW-1:0] aw_addr,
  output logic          w_valid,
  input  logic          w_ready,
  output logic [DW-1:0] w_data,
  input  logic          b_valid,
  output logic          b_ready,
  input  logic [1:0]    b_resp
);
  afc_mst_t mst;
  logic     aw_clear, w_clear;

  assign r_ready  = (mst == M_R);
  assign b_ready  = (mst == M_B);
  assign aw_clear = !aw_valid || aw_ready;
  assign w_clear  = !w_valid || w_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mst      <= M_IDLE;
      done     <= 1'b0;
      bad      <= 1'b0;
      rdata    <= '0;
      ar_valid <= 1'b0;
      ar_addr  <= '0;
      aw_valid <= 1'b0;
      aw_addr  <= '0;
      w_valid  <= 1'b0;
      w_data   <= '0;
    end else begin
      done <= 1'b0;
      case (mst)
        M_IDLE: begin
          if (go) begin
            if (is_wr) begin
              aw_valid <= 1'b1;
              w_valid  <= 1'b1;
              aw_addr  <= addr;
              w_data   <= wdata;
              mst      <= M_W;
            end else begin
              ar_valid <= 1'b1;
              ar_addr  <= addr;
              mst      <= M_AR;
            end
          end
        end
        M_AR: begin
          if (ar_ready) begin
            ar_valid <= 1'b0;
            mst      <= M_R;
          end
        end
        M_R: begin
          if (r_valid) begin
            rdata <= r_data;
            bad   <= (r_resp != RESP_OKAY);
            done  <= 1'b1;
            mst   <= M_IDLE;
          end
        end
        M_W: begin
          if (aw_ready) aw_valid <= 1'b0;
          if (w_ready)  w_valid  <= 1'b0;
          if (aw_clear && w_clear) mst <= M_B;
        end
        M_B: begin
          if (b_valid) begin
            bad  <= (b_resp != RESP_OKAY);
            done <= 1'b1;
            mst  <= M_IDLE;
          end
        end
        default: mst <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/afc_poll_timer.sv
module afc_poll_timer
  import accel_feed_pkg::*;
#(
  parameter int GAP_W   = 8,
  parameter int MIN_GAP = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] gap,
  output logic             expire
);
  localparam int unsigned GAP_MAX = (1 << GAP_W) - 1;

  logic [GAP_W-1:0] cnt;
  logic             run;
  logic [GAP_W-1:0] eff;

  always_comb begin
    int unsigned g;
    g   = floor_gap(int'(gap), MIN_GAP);
    if (g > GAP_MAX) g = GAP_MAX;
    eff = GAP_W'(g);
  end

  assign expire = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= eff - 1'b1;
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/afc_frame_writer.sv
module afc_frame_writer
  import accel_feed_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] size_bytes,
  output logic          active,
  input  logic          px_valid,
  output logic          px_ready,
  input  logic [DW-1:0] px_data,
  output logic          mw_start,
  output logic [AW-1:0] mw_addr,
  output logic [DW-1:0] mw_len,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic [DW-1:0] mw_data
);
  localparam int SHIFT = beat_shift(DW);

  logic [DW-1:0] remaining;
  logic [DW-1:0] beats;
  logic          fire;

  assign beats    = size_bytes >> SHIFT;
  assign mw_valid = px_valid && active;
  assign px_ready = mw_ready && active;
  assign mw_data  = px_data;
  assign fire     = mw_valid && mw_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
      active    <= 1'b0;
      mw_start  <= 1'b0;
      mw_addr   <= '0;
      mw_len    <= '0;
    end else begin
      mw_start <= 1'b0;
      if (load) begin
        mw_start  <= 1'b1;
        mw_addr   <= base;
        mw_len    <= beats;
        remaining <= beats;
        active    <= (beats != '0);
      end else if (fire) begin
        remaining <= remaining - 1'b1;
        if (remaining == DW'(1)) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/accel_feed_ctrl.sv
module accel_feed_ctrl
  import accel_feed_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter int          GAP_W     = 8,
  parameter int          MIN_GAP   = 16,
  parameter logic [AW-1:0] REG_BASE = '0,
  parameter logic [AW-1:0] OFS_VALID = 'h00,
  parameter logic [AW-1:0] OFS_ADDR  = 'h04,
  parameter logic [AW-1:0] OFS_SIZE  = 'h08,
  parameter logic [AW-1:0] OFS_NEXT  = 'h0C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_en,
  input  logic [GAP_W-1:0] poll_gap,
  output logic             m_ar_valid,
  input  logic             m_ar_ready,
  output logic [AW-1:0]    m_ar_addr,
  input  logic             m_r_valid,
  output logic             m_r_ready,
  input  logic [DW-1:0]    m_r_data,
  input  logic [1:0]       m_r_resp,
  output logic             m_aw_valid,
  input  logic             m_aw_ready,
  output logic [AW-1:0]    m_aw_addr,
  output logic             m_w_valid,
  input  logic             m_w_ready,
  output logic [DW-1:0]    m_w_data,
  input  logic             m_b_valid,
  output logic             m_b_ready,
  input  logic [1:0]       m_b_resp,
  input  logic             px_valid,
  output logic             px_ready,
  input  logic [DW-1:0]    px_data,
  output logic             mw_start,
  output logic [AW-1:0]    mw_addr,
  output logic [DW-1:0]    mw_len,
  output logic             mw_valid,
  input  logic             mw_ready,
  output logic [DW-1:0]    mw_data,
  input  logic             mw_done,
  output logic             err_flag
);
  afc_state_t    state;
  logic          sent;
  logic          req_state;
  logic          rq_go, rq_wr, rq_done, rq_bad;
  logic [AW-1:0] rq_addr;
  logic [DW-1:0] rq_wdata, rq_rdata;
  logic [AW-1:0] buf_addr;
  logic          fw_load, fw_active;
  logic          tm_load, tm_expire;
  logic          rsp_ok, valid_seen;

  // named events for the checker
  afc_state_t    st_code;
  logic          frame_active;
  assign st_code      = state;
  assign frame_active = fw_active;

  assign req_state = (state == S_RD_VALID) || (state == S_RD_ADDR) ||
                     (state == S_RD_SIZE)  || (state == S_NEXT_SET) ||
                     (state == S_NEXT_CLR);
  assign rq_go     = req_state && !sent;
  assign rq_wr     = (state == S_NEXT_SET) || (state == S_NEXT_CLR);
  assign rq_wdata  = (state == S_NEXT_SET) ? DW'(1) : '0;
  assign rsp_ok    = rq_done && !rq_bad;
  assign valid_seen = rq_rdata[0];

  always_comb begin
    case (state)
      S_RD_ADDR:              rq_addr = REG_BASE + OFS_ADDR;
      S_RD_SIZE:              rq_addr = REG_BASE + OFS_SIZE;
      S_NEXT_SET, S_NEXT_CLR: rq_addr = REG_BASE + OFS_NEXT;
      default:                rq_addr = REG_BASE + OFS_VALID;
    endcase
  end

  assign fw_load = (state == S_RD_SIZE) && rsp_ok;
  assign tm_load = (state == S_RD_VALID) && rsp_ok && !valid_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      sent     <= 1'b0;
      buf_addr <= '0;
      err_flag <= 1'b0;
    end else begin
      if (rq_go)        sent <= 1'b1;
      else if (rq_done) sent <= 1'b0;

      if (rq_done && rq_bad) begin
        err_flag <= 1'b1;
        state    <= S_HALT;
      end else begin
        case (state)
          S_IDLE:      if (start_en) state <= S_RD_VALID;
          S_RD_VALID:  if (rq_done) state <= valid_seen ? S_RD_ADDR : S_WAIT_GAP;
          S_WAIT_GAP:  if (tm_expire) state <= start_en ? S_RD_VALID : S_IDLE;
          S_RD_ADDR: begin
            if (rq_done) begin
              buf_addr <= AW'(rq_rdata);
              state    <= S_RD_SIZE;
            end
          end
          S_RD_SIZE:   if (rq_done) state <= S_STREAM;
          S_STREAM:    if (!fw_active) state <= S_WAIT_DONE;
          S_WAIT_DONE: if (mw_done) state <= S_NEXT_SET;
          S_NEXT_SET:  if (rq_done) state <= S_NEXT_CLR;
          S_NEXT_CLR:  if (rq_done) state <= start_en ? S_RD_VALID : S_IDLE;
          S_HALT:      state <= S_HALT;
          default:     state <= S_IDLE;
        endcase
      end
    end
  end

  afc_reg_master #(.AW(AW), .DW(DW)) u_mst (
    .clk(clk), .rst_n(rst_n),
    .go(rq_go), .is_wr(rq_wr), .addr(rq_addr), .wdata(rq_wdata),
    .done(rq_done), .bad(rq_bad), .rdata(rq_rdata),
    .ar_valid(m_ar_valid), .ar_ready(m_ar_ready), .ar_addr(m_ar_addr),
    .r_valid(m_r_valid), .r_ready(m_r_ready), .r_data(m_r_data), .r_resp(m_r_resp),
    .aw_valid(m_aw_valid), .aw_ready(m_aw_ready), .aw_addr(m_aw_addr),
    .w_valid(m_w_valid), .w_ready(m_w_ready), .w_data(m_w_data),
    .b_valid(m_b_valid), .b_ready(m_b_ready), .b_resp(m_b_resp)
  );

  afc_poll_timer #(.GAP_W(GAP_W), .MIN_GAP(MIN_GAP)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .gap(poll_gap), .expire(tm_expire)
  );

  afc_frame_writer #(.AW(AW), .DW(DW)) u_fw (
    .clk(clk), .rst_n(rst_n),
    .load(fw_load), .base(buf_addr), .size_bytes(rq_rdata),
    .active(fw_active),
    .px_valid(px_valid), .px_ready(px_ready), .px_data(px_data),
    .mw_start(mw_start), .mw_addr(mw_addr), .mw_len(mw_len),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_data(mw_data)
  );
endmodule

// File: rtl/afc_checker.sv
module afc_checker
  import accel_feed_pkg::*;
#(
  parameter int            AW        = 32,
  parameter int            DW        = 32,
  parameter logic [AW-1:0] NEXT_ADDR = 'h0C
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ar_valid,
  input logic          ar_ready,
  input logic [AW-1:0] ar_addr,
  input logic          aw_valid,
  input logic          aw_ready,
  input logic [AW-1:0] aw_addr,
  input logic [DW-1:0] w_data,
  input logic          mw_done,
  input logic          px_ready,
  input logic          err_flag,
  input afc_state_t    st_code
);
  logic done_seen;
  logic next_one;

  assign next_one = aw_valid && (aw_addr == NEXT_ADDR) && w_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n)                 done_seen <= 1'b0;
    else if (mw_done)           done_seen <= 1'b1;
    else if (next_one && aw_ready) done_seen <= 1'b0;
  end

  // R6
  p_next_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    next_one |-> done_seen);

  // R10
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R10
  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_flag) |-> (!ar_valid && !aw_valid && !px_ready));

  // R2
  p_ar_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && !ar_ready) |=> (ar_valid && $stable(ar_addr)));

  // R5
  p_px_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    px_ready |-> (st_code == S_STREAM));

  // R9
  p_idle_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_code == S_IDLE) && ($past(st_code) != S_IDLE)) |->
      (($past(st_code) == S_NEXT_CLR) || ($past(st_code) == S_WAIT_GAP)));
endmodule

bind accel_feed_ctrl afc_checker #(.AW(AW), .DW(DW), .NEXT_ADDR(REG_BASE + OFS_NEXT)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ar_valid(m_ar_valid), .ar_ready(m_ar_ready), .ar_addr(m_ar_addr),
  .aw_valid(m_aw_valid), .aw_ready(m_aw_ready), .aw_addr(m_aw_addr),
  .w_data(m_w_data), .mw_done(mw_done), .px_ready(px_ready),
  .err_flag(err_flag), .st_code(st_code)
);

// File: tb/accel_feed_ctrl_test.sv
`timescale 1ns/1ps
module accel_feed_ctrl_test;
  localparam int AW = 32, DW = 32, GAP_W = 8;
  localparam logic [31:0] A_VALID = 32'h00, A_ADDR = 32'h04, A_SIZE = 32'h08, A_NEXT = 32'h0C;
  localparam logic [31:0] RING = 32'h8000_0000;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic start_en = 0;
  logic [GAP_W-1:0] poll_gap = 8'd3;
  logic m_ar_valid, m_ar_ready, m_r_valid, m_r_ready;
  logic [AW-1:0] m_ar_addr, m_aw_addr, mw_addr;
  logic [DW-1:0] m_r_data, m_w_data, px_data, mw_len, mw_data;
  logic [1:0] m_r_resp, m_b_resp;
  logic m_aw_valid, m_aw_ready, m_w_valid, m_w_ready, m_b_valid, m_b_ready;
  logic px_valid, px_ready, mw_start, mw_valid, mw_ready, mw_done, err_flag;

  accel_feed_ctrl uut (.*);

  int n_checks = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int zeros_for(int f);
    return (f == 0) ? 2 : ((f == 5) ? 1 : 0);
  endfunction
  function automatic logic [31:0] ring_addr(int f);
    return RING + 32'((f % 3) * 32'h1000);
  endfunction
  function automatic logic [31:0] size_for(int f);
    return 32'(8 * ((f % 4) + 1));
  endfunction
  function automatic int eff_gap(int g);
    return (g < 16) ? 16 : g;
  endfunction

  // accelerator register slave
  bit bad_size = 0;
  int s_nx0 = 0, s_zeros = 0;
  assign m_ar_ready = 1'b1;
  assign m_aw_ready = 1'b1;
  assign m_w_ready  = 1'b1;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_r_valid <= 0; m_r_data <= 0; m_r_resp <= 0; m_b_valid <= 0; m_b_resp <= 0;
    end else begin
      if (m_ar_valid && m_ar_ready) begin
        m_r_valid <= 1; m_r_resp <= 0;
        case (m_ar_addr)
          A_VALID: begin
            if (s_zeros < zeros_for(s_nx0)) begin m_r_data <= 0; s_zeros <= s_zeros + 1; end
            else m_r_data <= 1;
          end
          A_ADDR: m_r_data <= ring_addr(s_nx0);
          A_SIZE: begin m_r_data <= size_for(s_nx0); if (bad_size) m_r_resp <= 2'b10; end
          default: m_r_data <= 0;
        endcase
      end else if (m_r_valid && m_r_ready) m_r_valid <= 0;
      if (m_aw_valid && m_w_valid) begin
        m_b_valid <= 1; m_b_resp <= 0;
        if (m_aw_addr == A_NEXT && m_w_data == 0) begin s_nx0 <= s_nx0 + 1; s_zeros <= 0; end
      end else if (m_b_valid && m_b_ready) m_b_valid <= 0;
    end
  end

  // pixel source and memory model
  int pv_cnt = 0, rdy_cnt = 0, m_got = 0, m_len = 0, m_dly = 0;
  bit m_busy = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      px_valid <= 0; px_data <= 0; mw_ready <= 0; mw_done <= 0; m_busy <= 0;
    end else begin
      pv_cnt <= pv_cnt + 1; rdy_cnt <= rdy_cnt + 1;
      px_valid <= ((pv_cnt + 1) % 5) != 4;
      mw_ready <= ((rdy_cnt + 1) % 3) != 2;
      if (px_valid && px_ready) px_data <= px_data + 1;
      mw_done <= 0;
      if (mw_start) begin
        m_len <= int'(mw_len); m_got <= (mw_valid && mw_ready) ? 1 : 0; m_busy <= 1; m_dly <= 0;
      end else if (m_busy) begin
        if (mw_valid && mw_ready) m_got <= m_got + 1;
        else if (m_got == m_len) begin
          m_dly <= m_dly + 1;
          if (m_dly == 4) begin mw_done <= 1; m_busy <= 0; end
        end
      end
    end
  end

  // monitor, sampled at the falling edge
  int cyc = 0, n_ar = 0, n_aw = 0, n_b = 0, nx1 = 0, nx0 = 0, dones = 0, n_ms = 0;
  int exp_rd = 0, last_valid_cyc = 0, fr_beats = 0, fr_len = 0;
  bit last_zero = 0, open_fr = 0;
  logic [31:0] last_ar = 0, exp_px = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (m_ar_valid && m_ar_ready) begin
        n_ar++;
        last_ar = m_ar_addr;
        chk(m_ar_addr == (exp_rd == 0 ? A_VALID : exp_rd == 1 ? A_ADDR : A_SIZE) && exp_rd < 3,
            "R2 read order", m_ar_addr, exp_rd);
        if (m_ar_addr == A_VALID && last_zero) begin
          chk(cyc - last_valid_cyc >= eff_gap(int'(poll_gap)) &&
              cyc - last_valid_cyc <= eff_gap(int'(poll_gap)) + 10,
              "R3 re-poll spacing", cyc - last_valid_cyc, eff_gap(int'(poll_gap)));
          last_zero = 0;
        end
        if (m_ar_addr == A_VALID) last_valid_cyc = cyc;
      end
      if (m_r_valid && m_r_ready) begin
        if (last_ar == A_VALID) begin
          if (m_r_data[0]) exp_rd = 1; else begin exp_rd = 0; last_zero = 1; end
        end else if (last_ar == A_ADDR) exp_rd = 2;
        else exp_rd = 3;
      end
      if (m_b_valid && m_b_ready) n_b++;
      if (m_aw_valid && m_aw_ready) begin
        chk(n_b == n_aw, "R7 prior write acknowledged", n_b, n_aw);
        n_aw++;
        if (m_aw_addr == A_NEXT && m_w_data == 1) begin
          chk(dones == nx1 + 1, "R6 next write after done", dones, nx1 + 1);
          nx1++;
        end else if (m_aw_addr == A_NEXT && m_w_data == 0) begin
          chk(nx1 == nx0 + 1, "R7 clear follows set", nx1, nx0 + 1);
          nx0++; exp_rd = 0;
        end
      end
      if (mw_start) begin
        n_ms++;
        chk(mw_addr == ring_addr(nx0), "R8 ring address", mw_addr, ring_addr(nx0));
        chk(mw_len == size_for(nx0) / 4, "R4 beat length", mw_len, size_for(nx0) / 4);
        fr_beats = 0; fr_len = int'(size_for(nx0) / 4); open_fr = 1;
      end
      if (px_ready && !open_fr) chk(0, "R5 px_ready outside frame", 1, 0);
      if (mw_valid && mw_ready) begin
        chk(open_fr && fr_beats < fr_len, "R5 beat within frame", fr_beats, fr_len);
        chk(mw_data == exp_px, "R5 beat data order", mw_data, exp_px);
        exp_px++; fr_beats++;
        if (fr_beats == fr_len) open_fr = 0;
      end
      if (mw_done) begin
        chk(fr_beats == fr_len, "R5 beats per frame", fr_beats, fr_len);
        dones++;
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    chk(0, "watchdog", cyc, 0);
    summary();
  end

  initial begin
    int snap_ar, snap_aw;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (30) @(negedge clk);
    // R1
    chk(n_ar == 0 && n_aw == 0, "R1 no bus activity before start", n_ar + n_aw, 0);
    chk(!px_ready, "R1 px_ready low before start", px_ready, 0);
    chk(!err_flag, "R1 err_flag low after reset", err_flag, 0);
    start_en = 1;
    while (nx0 < 3) @(negedge clk);
    poll_gap = 8'd40;
    // R8: frames repeat without new start
    while (n_ms < 7) @(negedge clk);
    chk(nx0 == 6, "R8 six frames done on one start", nx0, 6);
    start_en = 0;
    for (int i = 0; i < 2000 && nx0 < 7; i++) @(negedge clk);
    chk(nx0 == 7 && dones == 7, "R9 interrupted frame completes", nx0, 7);
    repeat (2) @(negedge clk);
    snap_ar = n_ar;
    repeat (120) @(negedge clk);
    chk(n_ar == snap_ar, "R9 idle after boundary", n_ar, snap_ar);
    chk(!err_flag, "R10 no error on OKAY", err_flag, 0);
    bad_size = 1;
    start_en = 1;
    for (int i = 0; i < 500 && !err_flag; i++) @(negedge clk);
    chk(err_flag, "R10 error latched", err_flag, 1);
    snap_ar = n_ar; snap_aw = n_aw;
    bad_size = 0;
    repeat (150) @(negedge clk);
    chk(n_ar == snap_ar && n_aw == snap_aw, "R10 halted bus", n_ar + n_aw, snap_ar + snap_aw);
    chk(err_flag && !px_ready, "R10 flag sticky", err_flag, 1);
    summary();
  end
endmodule